// File: doc/BRIEF.md
# Infrared Pulse Run-Length Sampler

This block takes the one-bit output of a consumer infrared receiver and turns it into a stream of run-length bytes. Each byte holds the line level and the length of one run of that level. The raw pin passes through a two-flop synchronizer, an optional polarity inversion and a sampler. The sampler fires once every `TICK_DIV` module clocks. Short glitches are dropped by a programmable noise threshold. Runs longer than 128 samples are split into full-length pieces.

A packet opens on the first pulse sample. It closes when the line stays at space for longer than `(idle threshold + 1) * IDLE_UNIT` samples. The block then emits the last space byte, raises a packet-end strobe and waits for the next pulse. The downstream receive queue takes the bytes through a plain valid/data push interface.

The control state machine has three states.
- OFF: the block is disabled, and its counters and packet state are cleared.
- WAIT: the block is enabled and ignores space until a pulse sample arrives.
- RUN: a run is being measured.

It has four transitions.
- OFF→WAIT: the configuration enables the block.
- WAIT→RUN: the first pulse sample arrives.
- RUN→WAIT: the idle limit is exceeded.
- any state→OFF: an enable is withdrawn.

Top module: `ir_runlen_sampler`

## Requirements
- R1: While enabled, the input is sampled once every `TICK_DIV` clocks. At most one byte is emitted per sample, one clock after the sample that completes it.
- R2: Output byte bit 7 is the level (1 = pulse, 0 = space). Bits 6:0 hold the run length in samples minus one.
- R3: With `cfg_invert` = 1 the synchronized input is inverted before sampling, so a low pin counts as pulse.
- R4: A run that ends with fewer samples than `cfg_noise_thr` is dropped. Thresholds 0 and 1 drop nothing. A run that has already been split is never dropped.
- R5: When a run reaches its 129th sample, a byte with length field 127 is emitted and counting restarts at 1 with the same level.
- R6: When a space run reaches sample `L+1`, where `L = (cfg_idle_thr+1)*IDLE_UNIT`, the packet ends. The remaining space samples are emitted (subject to R4), and `rl_pkt_end` pulses in the same clock. The total space emitted for that run is exactly `L` samples.
- R7: Space before the first pulse, and space after a packet end, produce no bytes. The next packet starts on the next pulse sample.
- R8: The block is enabled only when `cfg_global_en` = 1, `cfg_rx_en` = 1 and `cfg_mode` = 2'b11. Otherwise `rl_valid` and `rl_pkt_end` stay 0. Both are 0 after reset.
- R9: Withdrawing the enable clears the run counters and the packet state. After re-enabling, lengths count only samples taken after the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_raw | input | 1 | Raw receiver pin, asynchronous |
| cfg_global_en | input | 1 | Global enable |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_mode | input | 2 | Operating mode; 2'b11 selects infrared receive |
| cfg_invert | input | 1 | Invert input polarity |
| cfg_noise_thr | input | 6 | Minimum run length kept, in samples |
| cfg_idle_thr | input | 8 | Idle limit in units of IDLE_UNIT samples, minus one |
| rl_valid | output | 1 | Byte push strobe |
| rl_byte | output | 8 | Run-length byte: level in bit 7, length-1 in bits 6:0 |
| rl_pkt_end | output | 1 | Packet-end strobe |

## Verification
The bench sweeps noise and idle thresholds across several waveforms and compares the byte stream with an arithmetic model of the requirements. The chosen runs sit exactly at the split boundary (128, 129 and 130 samples) and at idle limits both below and above 128 samples. An off-by-one in the split or idle compare would show up as one length of 126 or 128 samples, or as a missing zero-length tail byte. Glitch runs just below and at the noise threshold catch a filter that uses the wrong comparison. A second packet after an idle end would expose a sampler that keeps emitting space bytes instead of waiting for a pulse. A disable taken mid-run catches counters that survive the enable, because the first byte after re-enabling would then carry the stale length.

// File: rtl/ir_rl_pkg.sv
package ir_rl_pkg;

    localparam int RUN_MAX = 128;
    localparam int LEN_W   = $clog2(RUN_MAX);
    localparam int CNT_W   = $clog2(RUN_MAX + 1);
    localparam logic [1:0] MODE_IR_RX = 2'b11;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_WAIT,
        ST_RUN
    } rl_state_t;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_START,
        ACT_INC,
        ACT_CHUNK,
        ACT_CLEAR
    } rl_act_t;

    typedef struct packed {
        logic             level;
        logic [LEN_W-1:0] len_m1;
    } rl_byte_t;

endpackage

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
    parameter int TICK_DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!en) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick = en && (div_q == LAST);

endmodule

// File: rtl/ir_front.sv
module ir_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ir_raw,
    input  logic invert,
    output logic level
);
    logic [SYNC_STAGES-1:0] sync_q;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sync_q[g] <= 1'b0;
                end else if (g == 0) begin
                    sync_q[g] <= ir_raw;
                end else begin
                    sync_q[g] <= sync_q[(g > 0) ? g - 1 : 0];
                end
            end
        end
    endgenerate

    // level 1 = pulse, after optional inversion
    assign level = sync_q[SYNC_STAGES-1] ^ invert;

endmodule

// File: rtl/ir_run_fsm.sv
module ir_run_fsm
    import ir_rl_pkg::*;
#(
    parameter int IDLE_UNIT  = 128,
    parameter int IDLE_THR_W = 8,
    parameter int NOISE_W    = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic                  tick,
    input  logic                  level,
    input  logic [NOISE_W-1:0]    noise_thr,
    input  logic [IDLE_THR_W-1:0] idle_thr,
    output logic                  out_valid,
    output logic [7:0]            out_data,
    output logic                  pkt_end
);
    localparam int IDLE_W = $clog2((2 ** IDLE_THR_W) * IDLE_UNIT + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(RUN_MAX);

    rl_state_t         state_q, state_d;
    rl_act_t           act;
    logic              lvl_q;
    logic              split_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDLE_W-1:0] idle_q;
    logic [IDLE_W-1:0] idle_limit;
    logic              keep_run;
    logic              emit;
    logic              end_evt;
    rl_byte_t          emit_byte;

    assign idle_limit = (IDLE_W'(idle_thr) + IDLE_W'(1)) * IDLE_W'(IDLE_UNIT);
    assign keep_run   = split_q || (cnt_q >= CNT_W'(noise_thr));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and run decisions
    always_comb begin
        state_d          = state_q;
        act              = ACT_HOLD;
        emit             = 1'b0;
        end_evt          = 1'b0;
        emit_byte.level  = lvl_q;
        emit_byte.len_m1 = LEN_W'(cnt_q - CNT_W'(1));
        unique case (state_q)
            ST_OFF: begin
                act = ACT_CLEAR;
                if (en) begin
                    state_d = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (!en) begin
                    state_d = ST_OFF;
                end else if (tick && level) begin
                    state_d = ST_RUN;
                    act     = ACT_START;
                end
            end
            ST_RUN: begin
                if (!en) begin
                    state_d = ST_OFF;
                end else if (tick) begin
                    if (level != lvl_q) begin
                        emit = keep_run;
                        act  = ACT_START;
                    end else if (!lvl_q && (idle_q == idle_limit)) begin
                        emit    = keep_run;
                        end_evt = 1'b1;
                        act     = ACT_CLEAR;
                        state_d = ST_WAIT;
                    end else if (cnt_q == CNT_FULL) begin
                        emit = 1'b1;
                        act  = ACT_CHUNK;
                    end else begin
                        act = ACT_INC;
                    end
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // run datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q   <= 1'b0;
            split_q <= 1'b0;
            cnt_q   <= '0;
            idle_q  <= '0;
        end else if (!en) begin
            lvl_q   <= 1'b0;
            split_q <= 1'b0;
            cnt_q   <= '0;
            idle_q  <= '0;
        end else begin
            unique case (act)
                ACT_START: begin
                    lvl_q   <= level;
                    split_q <= 1'b0;
                    cnt_q   <= CNT_W'(1);
                    idle_q  <= level ? '0 : IDLE_W'(1);
                end
                ACT_INC: begin
                    cnt_q  <= cnt_q + CNT_W'(1);
                    idle_q <= lvl_q ? '0 : idle_q + IDLE_W'(1);
                end
                ACT_CHUNK: begin
                    split_q <= 1'b1;
                    cnt_q   <= CNT_W'(1);
                    idle_q  <= lvl_q ? '0 : idle_q + IDLE_W'(1);
                end
                ACT_CLEAR: begin
                    lvl_q   <= 1'b0;
                    split_q <= 1'b0;
                    cnt_q   <= '0;
                    idle_q  <= '0;
                end
                default: begin
                    lvl_q <= lvl_q;
                end
            endcase
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= 8'h00;
            pkt_end   <= 1'b0;
        end else begin
            out_valid <= emit;
            pkt_end   <= end_evt;
            if (emit) begin
                out_data <= emit_byte;
            end
        end
    end

endmodule

// File: rtl/ir_runlen_sampler.sv
module ir_runlen_sampler
    import ir_rl_pkg::*;
#(
    parameter int TICK_DIV    = 64,
    parameter int IDLE_UNIT   = 128,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ir_raw,
    input  logic       cfg_global_en,
    input  logic       cfg_rx_en,
    input  logic [1:0] cfg_mode,
    input  logic       cfg_invert,
    input  logic [5:0] cfg_noise_thr,
    input  logic [7:0] cfg_idle_thr,
    output logic       rl_valid,
    output logic [7:0] rl_byte,
    output logic       rl_pkt_end
);
    logic en;
    logic tick;
    logic level;

    assign en = cfg_global_en && cfg_rx_en && (cfg_mode == MODE_IR_RX);

    ir_front #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_front (
        .clk    (clk),
        .rst_n  (rst_n),
        .ir_raw (ir_raw),
        .invert (cfg_invert),
        .level  (level)
    );

    ir_tick_gen #(
        .TICK_DIV (TICK_DIV)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .tick  (tick)
    );

    ir_run_fsm #(
        .IDLE_UNIT  (IDLE_UNIT),
        .IDLE_THR_W (8),
        .NOISE_W    (6)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .tick      (tick),
        .level     (level),
        .noise_thr (cfg_noise_thr),
        .idle_thr  (cfg_idle_thr),
        .out_valid (rl_valid),
        .out_data  (rl_byte),
        .pkt_end   (rl_pkt_end)
    );

endmodule

// File: rtl/ir_rl_checker.sv
module ir_rl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_global_en,
    input logic       cfg_rx_en,
    input logic [1:0] cfg_mode,
    input logic       rl_valid,
    input logic [7:0] rl_byte,
    input logic       rl_pkt_end
);
    logic cfg_on;
    assign cfg_on = cfg_global_en && cfg_rx_en && (cfg_mode == 2'b11);

    // R1: samples are at least two clocks apart, so bytes never come back to back
    a_r1_one_per_tick: assert property (@(posedge clk) disable iff (!rst_n)
        rl_valid |=> !rl_valid);

    // R8: a disabled configuration produces nothing on the next clock
    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_on |=> (!rl_valid && !rl_pkt_end));

    // R6: the byte that closes a packet is always a space byte
    a_r6_end_is_space: assert property (@(posedge clk) disable iff (!rst_n)
        (rl_pkt_end && rl_valid) |-> !rl_byte[7]);

    // R6: packet end is a single-clock strobe
    a_r6_end_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rl_pkt_end |=> !rl_pkt_end);

endmodule

bind ir_runlen_sampler ir_rl_checker u_rl_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_global_en (cfg_global_en),
    .cfg_rx_en     (cfg_rx_en),
    .cfg_mode      (cfg_mode),
    .rl_valid      (rl_valid),
    .rl_byte       (rl_byte),
    .rl_pkt_end    (rl_pkt_end)
);

// File: tb/test_ir_runlen_sampler.sv
module test_ir_runlen_sampler;
    localparam int CLK_PERIOD = 10;
    localparam int DIV  = 4;
    localparam int UNIT = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ir_raw = 1'b0;
    logic       gen = 1'b0;
    logic       rxen = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       inv = 1'b0;
    logic [5:0] nthr = '0;
    logic [7:0] ithr = '0;
    logic       rl_valid;
    logic [7:0] rl_byte;
    logic       rl_pkt_end;

    always #(CLK_PERIOD/2) clk = ~clk;

    ir_runlen_sampler #(.TICK_DIV(DIV), .IDLE_UNIT(UNIT)) i_ir_runlen_sampler (
        .clk(clk), .rst_n(rst_n), .ir_raw(ir_raw),
        .cfg_global_en(gen), .cfg_rx_en(rxen), .cfg_mode(mode),
        .cfg_invert(inv), .cfg_noise_thr(nthr), .cfg_idle_thr(ithr),
        .rl_valid(rl_valid), .rl_byte(rl_byte), .rl_pkt_end(rl_pkt_end)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;
    bit cap_en = 1'b0;
    logic [9:0] got[$];
    int         stamp[$];
    logic [9:0] exp_q[$];
    int rl[32];
    int rn[32];
    int nr = 0;

    always @(posedge clk) cyc++;

    // entry = {end, valid, byte or 0}
    always @(negedge clk) begin
        if (cap_en && (rl_valid || rl_pkt_end)) begin
            got.push_back({rl_pkt_end, rl_valid, rl_valid ? rl_byte : 8'h00});
            stamp.push_back(cyc);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic add(input int l, input int n);
        rl[nr] = l;
        rn[nr] = n;
        nr++;
    endtask

    task automatic pat(input int p, input int limit);
        nr = 0;
        case (p)
            0: begin add(0,3); add(1,5); add(0,2); add(1,1); add(0,7); add(1,3); add(0,limit+10); end
            1: begin add(1,130); add(0,128); add(1,129); add(0,4); add(1,2); add(0,limit+10); end
            2: begin add(1,4); add(0,limit+5); add(1,6); add(0,2); add(1,1); add(0,limit+10); end
            3: begin add(1,1); add(0,1); add(1,1); add(0,1); add(1,1); add(0,limit+10); end
            default: begin add(1,5); add(0,3); add(1,2); add(0,limit+10); end
        endcase
    endtask

    task automatic push_run(input int lvl, input int len, input bit fin, input int noise);
        int k;
        int r;
        bit l;
        l = (lvl != 0);
        k = (len - 1) / 128;
        for (int j = 0; j < k; j++) exp_q.push_back({2'b01, l, 7'd127});
        r = len - 128 * k;
        if (k > 0 || r >= noise) exp_q.push_back({fin, 1'b1, l, 7'(r - 1)});
        else if (fin) exp_q.push_back(10'h200);
    endtask

    task automatic build_exp(input int noise, input int limit);
        bit inpkt;
        inpkt = 1'b0;
        exp_q.delete();
        for (int i = 0; i < nr; i++) begin
            if (!inpkt) begin
                if (rl[i] == 0) continue;
                inpkt = 1'b1;
            end
            if (rl[i] == 1 || rn[i] <= limit) push_run(rl[i], rn[i], 1'b0, noise);
            else begin
                push_run(0, limit, 1'b1, noise);
                inpkt = 1'b0;
            end
        end
    endtask

    task automatic drive(input bit invb);
        for (int i = 0; i < nr; i++) begin
            ir_raw = (rl[i] != 0) ^ invb;
            repeat (rn[i] * DIV) @(negedge clk);
        end
    endtask

    task automatic compare(input string tag);
        int n;
        check(got.size() == exp_q.size(), {tag, " count"}, got.size(), exp_q.size());
        n = (got.size() < exp_q.size()) ? got.size() : exp_q.size();
        for (int i = 0; i < n; i++) check(got[i] == exp_q[i], tag, got[i], exp_q[i]);
    endtask

    task automatic run_case(input int p, input int noise, input int it, input bit invb,
                            input bit gen_v, input logic [1:0] mode_v, input string tag);
        int limit;
        limit = (it + 1) * UNIT;
        pat(p, limit);
        @(negedge clk);
        nthr = 6'(noise);
        ithr = 8'(it);
        inv  = invb;
        ir_raw = invb;
        got.delete();
        stamp.delete();
        cap_en = 1'b1;
        gen = gen_v; rxen = 1'b1; mode = mode_v;
        drive(invb);
        repeat (4) @(negedge clk);
        cap_en = 1'b0;
        gen = 1'b0;
        @(negedge clk);
        build_exp(noise, limit);
        if (!(gen_v && mode_v == 2'b11)) exp_q.delete();
        compare(tag);
    endtask

    initial begin
        int nz[4];
        int iz[3];
        nz[0] = 0; nz[1] = 1; nz[2] = 2; nz[3] = 6;
        iz[0] = 0; iz[1] = 3; iz[2] = 9;
        repeat (5) @(negedge clk);
        check(rl_valid == 1'b0 && rl_pkt_end == 1'b0, "R8 reset", {rl_valid, rl_pkt_end}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R4 R5 R6 R7: sweep of thresholds over three waveforms
        for (int p = 0; p < 3; p++)
            for (int a = 0; a < 4; a++)
                for (int b = 0; b < 3; b++)
                    run_case(p, nz[a], iz[b], 1'b0, 1'b1, 2'b11,
                             (p == 1) ? "R5 R2 R6" : (p == 2) ? "R7 R6 R4" : "R2 R4 R6");

        // R3: inverted pin gives the same stream
        run_case(0, 1, 0, 1'b1, 1'b1, 2'b11, "R3");
        run_case(1, 2, 3, 1'b1, 1'b1, 2'b11, "R3");

        // R8: wrong mode, or global enable off, gives nothing
        run_case(0, 1, 0, 1'b0, 1'b1, 2'b01, "R8 mode");
        run_case(0, 1, 0, 1'b0, 1'b0, 2'b11, "R8 global");

        // R1: single-sample runs produce bytes exactly one sample period apart
        run_case(3, 0, 0, 1'b0, 1'b1, 2'b11, "R1");
        check(stamp.size() >= 3, "R1 bytes", stamp.size(), 3);
        if (stamp.size() >= 3) begin
            check(stamp[1] - stamp[0] == DIV, "R1 gap", stamp[1] - stamp[0], DIV);
            check(stamp[2] - stamp[1] == DIV, "R1 gap", stamp[2] - stamp[1], DIV);
        end

        // R9: disable mid-run, toggle the pin, re-enable and measure afresh
        @(negedge clk);
        nthr = 6'd0; ithr = 8'd0; inv = 1'b0;
        gen = 1'b1; rxen = 1'b1; mode = 2'b11;
        ir_raw = 1'b1;
        repeat (50 * DIV) @(negedge clk);
        got.delete();
        cap_en = 1'b1;
        rxen = 1'b0;
        for (int t = 0; t < 12; t++) begin
            ir_raw = t[1];
            @(negedge clk);
        end
        check(got.size() == 0, "R9 quiet while disabled", got.size(), 0);
        ir_raw = 1'b1;
        @(negedge clk);
        pat(4, UNIT);
        got.delete();
        rxen = 1'b1;
        drive(1'b0);
        repeat (4) @(negedge clk);
        cap_en = 1'b0;
        gen = 1'b0;
        build_exp(0, UNIT);
        compare("R9");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule